// File: doc/BRIEF.md
# Dual-Version Reconfigurable Cache Array

This block is the storage core of a four-way L1 data cache with 64-byte lines and 48-bit addresses. Every row of every way holds two line copies, an upper one and a lower one. A mode register decides how the copies are used. In general mode the array is a 64KB single-version cache, and two neighbouring sets of one way share a row, one in each copy. In transactional mode the array is a 32KB cache in which the upper copy holds the speculative value and the lower copy holds the committed value. Whole-line transfers between the two copies take one request each.

Requests arrive one per cycle on a valid/ready channel. Each request carries an opcode, a way, an address and a full line of write data. The block decodes the address into a row, a copy and a tag slot. It carries out the line operation and answers one cycle later with read data, a per-way tag hit vector and an error flag. The controlling cache uses the hit vector to choose a way, then issues copy, restore, dual-write or whole-array snapshot operations as its transaction protocol requires. The mode can be changed only when no line is valid.

Top module: `dvcache_array`

## Requirements
- R1: After a synchronous reset, the mode is general (`tm_mode`=0), `rsp_valid` is 0 and no tag slot is valid, so no lookup hits.
- R2: `req_ready` is always 1. Every accepted request gives exactly one response with `rsp_valid`=1 on the next cycle, and no response follows an idle cycle. Opcodes: 0 upper read, 1 upper write, 2 lower read, 3 lower write, 4 copy upper to lower, 5 copy lower to upper, 6 dual write, 7 snapshot all, 8 invalidate line, 9 invalidate all, 10 set mode from `req_wdata[0]`. `rsp_data` returns the addressed copy as it was before the request, and returns 0 for non-read opcodes.
- R3: In general mode the set index is A13..A6, the row is A13..A7 and A6 picks the copy (0 upper, 1 lower). Read and write opcodes follow A6 whatever copy their opcode names.
- R4: In transactional mode the row is A12..A6 and A13 does not affect which data row is used. Upper opcodes reach the upper copy and lower opcodes reach the lower copy, independently of each other.
- R5: Opcodes 1, 3 and 6 store tag A47..A13 in the way's tag slot and mark it valid. The tag slot is A13..A6 in general mode and {0, A12..A6} in transactional mode. `rsp_hit[w]` is 1 when way w's slot is valid and its tag matches, judged before the request takes effect and for all ways whatever `req_way` is.
- R6: In transactional mode opcode 4 copies the addressed upper line into its lower copy, and opcode 5 copies the lower line back into the upper copy.
- R7: In transactional mode opcode 6 writes the same data to both copies of the addressed line.
- R8: In transactional mode opcode 7 copies every upper line of every way into its lower copy in one request.
- R9: In general mode opcodes 4 to 7 are rejected with `rsp_err`=1 and change nothing.
- R10: Opcode 8 clears one tag slot's valid bit and opcode 9 clears all of them. Opcode 10 is rejected with `rsp_err`=1 while any slot is valid. The mode register changes only through an accepted opcode 10.
- R11: Opcodes 11 to 15 are rejected with `rsp_err`=1 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_op | input | 4 | Operation code |
| req_way | input | 2 | Target way |
| req_addr | input | 48 | Byte address |
| req_wdata | input | 512 | Line write data; bit 0 is the mode for opcode 10 |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 512 | Line read data |
| rsp_hit | output | 4 | Per-way tag hit for the request address |
| rsp_err | output | 1 | Request rejected |
| tm_mode | output | 1 | Current mode: 1 transactional, 0 general |

## Verification
Two things can happen in the same cycle: the response to a read, and a write to that same line that is already being accepted behind it. The bench issues a read and, on the next cycle, a write to the same way and line. It then requires the read response to carry the old line and the pre-write hit vector, and a later read to return the new line. A tag install and its own lookup also share a cycle. The vectors check that a write reports the hit state from before its own install, and that the next request sees the installed tag.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

    localparam int ADDR_W = 48;
    localparam int LINE_W = 512;
    localparam int WAYS   = 4;
    localparam int OFF_W  = 6;
    localparam int IDX_W  = 8;
    localparam int ROW_W  = IDX_W - 1;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W + 1;
    localparam int WAY_W  = $clog2(WAYS);

    typedef enum logic [3:0] {
        OP_URD      = 4'd0,
        OP_UWR      = 4'd1,
        OP_LRD      = 4'd2,
        OP_LWR      = 4'd3,
        OP_STORE    = 4'd4,
        OP_RESTORE  = 4'd5,
        OP_DUAL     = 4'd6,
        OP_STOREALL = 4'd7,
        OP_INVAL    = 4'd8,
        OP_INVALL   = 4'd9,
        OP_SETMODE  = 4'd10
    } op_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [IDX_W-1:0] tidx;
        logic [TAG_W-1:0] tag;
        logic rd;
        logic rd_lo;
        logic wr_up;
        logic wr_lo;
        logic up_from_lo;
        logic lo_from_up;
        logic storeall;
        logic install;
        logic inval;
        logic invall;
        logic setmode;
        logic err;
    } dec_t;

    function automatic logic is_tm_only(input logic [3:0] op);
        return (op >= OP_STORE) && (op <= OP_STOREALL);
    endfunction

endpackage

// File: rtl/dvc_decode.sv
module dvc_decode
    import dvc_pkg::*;
(
    input  logic              mode,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic a_lo;

    always_comb begin
        dec     = '0;
        a_lo    = addr[OFF_W];
        dec.tag = addr[ADDR_W-1 : OFF_W+IDX_W-1];
        if (mode) begin
            dec.row  = addr[OFF_W +: ROW_W];
            dec.tidx = {1'b0, addr[OFF_W +: ROW_W]};
        end else begin
            dec.row  = addr[OFF_W+1 +: ROW_W];
            dec.tidx = addr[OFF_W +: IDX_W];
        end
        if (!mode && is_tm_only(op)) begin
            dec.err = 1'b1;
        end else begin
            case (op)
                OP_URD: begin
                    dec.rd    = 1'b1;
                    dec.rd_lo = mode ? 1'b0 : a_lo;
                end
                OP_LRD: begin
                    dec.rd    = 1'b1;
                    dec.rd_lo = mode ? 1'b1 : a_lo;
                end
                OP_UWR: begin
                    dec.install = 1'b1;
                    dec.wr_up   = mode ? 1'b1 : !a_lo;
                    dec.wr_lo   = mode ? 1'b0 : a_lo;
                end
                OP_LWR: begin
                    dec.install = 1'b1;
                    dec.wr_up   = mode ? 1'b0 : !a_lo;
                    dec.wr_lo   = mode ? 1'b1 : a_lo;
                end
                OP_STORE: begin
                    dec.wr_lo      = 1'b1;
                    dec.lo_from_up = 1'b1;
                end
                OP_RESTORE: begin
                    dec.wr_up      = 1'b1;
                    dec.up_from_lo = 1'b1;
                end
                OP_DUAL: begin
                    dec.install = 1'b1;
                    dec.wr_up   = 1'b1;
                    dec.wr_lo   = 1'b1;
                end
                OP_STOREALL: dec.storeall = 1'b1;
                OP_INVAL:    dec.inval    = 1'b1;
                OP_INVALL:   dec.invall   = 1'b1;
                OP_SETMODE:  dec.setmode  = 1'b1;
                default:     dec.err      = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dvc_tags.sv
module dvc_tags #(
    parameter int WAYS  = 4,
    parameter int IDX_W = 8,
    parameter int TAG_W = 35,
    localparam int SETS  = 1 << IDX_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] tidx,
    input  logic [TAG_W-1:0] tag,
    input  logic [WAY_W-1:0] way,
    input  logic             install,
    input  logic             inval,
    input  logic             invall,
    output logic [WAYS-1:0]  hit,
    output logic             any_valid
);
    logic [TAG_W-1:0] tag_mem [WAYS][SETS];
    logic [SETS-1:0]  vld [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit[w] = vld[w][tidx] && (tag_mem[w][tidx] == tag);

        always_ff @(posedge clk) begin
            if (rst || invall) begin
                vld[w] <= '0;
            end else if (way == WAY_W'(w)) begin
                if (install) begin
                    vld[w][tidx]     <= 1'b1;
                    tag_mem[w][tidx] <= tag;
                end else if (inval) begin
                    vld[w][tidx] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int w = 0; w < WAYS; w++) any_valid = any_valid | (|vld[w]);
    end
endmodule

// File: rtl/dvc_data.sv
module dvc_data #(
    parameter int WAYS   = 4,
    parameter int ROW_W  = 7,
    parameter int LINE_W = 512,
    localparam int ROWS  = 1 << ROW_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic [WAY_W-1:0]  way,
    input  logic [ROW_W-1:0]  row,
    input  logic [LINE_W-1:0] wdata,
    input  logic              wr_up,
    input  logic              wr_lo,
    input  logic              up_from_lo,
    input  logic              lo_from_up,
    input  logic              storeall,
    output logic [LINE_W-1:0] up_line,
    output logic [LINE_W-1:0] lo_line
);
    logic [LINE_W-1:0] up_mem [WAYS][ROWS];
    logic [LINE_W-1:0] lo_mem [WAYS][ROWS];

    assign up_line = up_mem[way][row];
    assign lo_line = lo_mem[way][row];

    always_ff @(posedge clk) begin
        if (storeall) begin
            for (int w = 0; w < WAYS; w++)
                for (int r = 0; r < ROWS; r++)
                    lo_mem[w][r] <= up_mem[w][r];
        end else begin
            if (wr_up) up_mem[way][row] <= up_from_lo ? lo_line : wdata;
            if (wr_lo) lo_mem[way][row] <= lo_from_up ? up_line : wdata;
        end
    end
endmodule

// File: rtl/dvcache_array.sv
module dvcache_array
    import dvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_op,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic [WAYS-1:0]   rsp_hit,
    output logic              rsp_err,
    output logic              tm_mode
);
    dec_t              dec;
    logic              any_valid;
    logic              reject;
    logic              go;
    logic [WAYS-1:0]   hit;
    logic [LINE_W-1:0] up_line;
    logic [LINE_W-1:0] lo_line;

    assign req_ready = 1'b1;

    dvc_decode u_dec (
        .mode (tm_mode),
        .op   (req_op),
        .addr (req_addr),
        .dec  (dec)
    );

    assign reject = dec.err || (dec.setmode && any_valid);
    assign go     = req_valid && !reject;

    dvc_tags #(.WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .tidx      (dec.tidx),
        .tag       (dec.tag),
        .way       (req_way),
        .install   (go && dec.install),
        .inval     (go && dec.inval),
        .invall    (go && dec.invall),
        .hit       (hit),
        .any_valid (any_valid)
    );

    dvc_data #(.WAYS(WAYS), .ROW_W(ROW_W), .LINE_W(LINE_W)) u_data (
        .clk        (clk),
        .way        (req_way),
        .row        (dec.row),
        .wdata      (req_wdata),
        .wr_up      (go && dec.wr_up),
        .wr_lo      (go && dec.wr_lo),
        .up_from_lo (dec.up_from_lo),
        .lo_from_up (dec.lo_from_up),
        .storeall   (go && dec.storeall),
        .up_line    (up_line),
        .lo_line    (lo_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_hit   <= '0;
            rsp_err   <= 1'b0;
            tm_mode   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && reject;
            rsp_hit   <= req_valid ? hit : '0;
            rsp_data  <= (go && dec.rd) ? (dec.rd_lo ? lo_line : up_line) : '0;
            if (go && dec.setmode) tm_mode <= req_wdata[0];
        end
    end
endmodule

// File: rtl/dvc_checker.sv
module dvc_checker
    import dvc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_op,
    input logic       rsp_valid,
    input logic       rsp_err,
    input logic       tm_mode
);
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!tm_mode && !rsp_valid)); // R1

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid); // R2

    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2

    AST_PLAIN_READ_OK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_URD) |=> !rsp_err); // R3

    AST_GENERAL_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !tm_mode && req_op >= OP_STORE && req_op <= OP_STOREALL) |=> rsp_err); // R9

    AST_MODE_BY_REQ: assert property (@(posedge clk) disable iff (rst)
        !$stable(tm_mode) |-> $past(req_valid && req_op == OP_SETMODE)); // R10

    AST_BAD_OP_REJECT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op > OP_SETMODE) |=> rsp_err); // R11
endmodule

bind dvcache_array dvc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .tm_mode   (tm_mode)
);

// File: tb/tb_dvcache_array.sv
module tb_dvcache_array;
    localparam logic [3:0] URD = 4'd0, UWR = 4'd1, LRD = 4'd2, LWR = 4'd3,
                           STO = 4'd4, RES = 4'd5, DUA = 4'd6, SALL = 4'd7,
                           INV = 4'd8, INVA = 4'd9, SMODE = 4'd10, BAD = 4'd12;
    localparam logic [34:0] T1 = 35'h100, T2 = 35'h200, T3 = 35'h300,
                            T3X = 35'h301, T4 = 35'h400;

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  way;
        logic [34:0] tag;
        logic [6:0]  low;
        logic [31:0] wpat;
        logic        chk_d;
        logic [31:0] dpat;
        logic [3:0]  hit;
        logic        err;
        logic        mode;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        // general mode, R1 R3 R5 R9 R10 R11
        '{URD,  2'd0, T1,  7'h10, 32'h0,        1'b0, 32'h0,        4'b0000, 1'b0, 1'b0, 4'd1},
        '{UWR,  2'd0, T1,  7'h10, 32'hAAAA0001, 1'b0, 32'h0,        4'b0000, 1'b0, 1'b0, 4'd5},
        '{UWR,  2'd0, T1,  7'h11, 32'hBBBB0002, 1'b0, 32'h0,        4'b0000, 1'b0, 1'b0, 4'd3},
        '{URD,  2'd0, T1,  7'h10, 32'h0,        1'b1, 32'hAAAA0001, 4'b0001, 1'b0, 1'b0, 4'd3},
        '{URD,  2'd0, T1,  7'h11, 32'h0,        1'b1, 32'hBBBB0002, 4'b0001, 1'b0, 1'b0, 4'd3},
        '{STO,  2'd0, T1,  7'h10, 32'h0,        1'b0, 32'h0,        4'b0001, 1'b1, 1'b0, 4'd9},
        '{LRD,  2'd0, T1,  7'h11, 32'h0,        1'b1, 32'hBBBB0002, 4'b0001, 1'b0, 1'b0, 4'd9},
        '{DUA,  2'd0, T1,  7'h10, 32'hDDDD0004, 1'b0, 32'h0,        4'b0001, 1'b1, 1'b0, 4'd9},
        '{URD,  2'd0, T1,  7'h10, 32'h0,        1'b1, 32'hAAAA0001, 4'b0001, 1'b0, 1'b0, 4'd9},
        '{UWR,  2'd2, T2,  7'h10, 32'hCCCC0003, 1'b0, 32'h0,        4'b0000, 1'b0, 1'b0, 4'd5},
        '{URD,  2'd2, T2,  7'h10, 32'h0,        1'b1, 32'hCCCC0003, 4'b0100, 1'b0, 1'b0, 4'd5},
        '{URD,  2'd0, T2,  7'h10, 32'h0,        1'b1, 32'hAAAA0001, 4'b0100, 1'b0, 1'b0, 4'd5},
        '{BAD,  2'd0, T1,  7'h10, 32'h0,        1'b0, 32'h0,        4'b0001, 1'b1, 1'b0, 4'd11},
        '{SMODE,2'd0, T1,  7'h10, 32'h1,        1'b0, 32'h0,        4'b0001, 1'b1, 1'b0, 4'd10},
        '{INVA, 2'd0, T1,  7'h10, 32'h0,        1'b0, 32'h0,        4'b0001, 1'b0, 1'b0, 4'd10},
        '{URD,  2'd0, T1,  7'h10, 32'h0,        1'b1, 32'hAAAA0001, 4'b0000, 1'b0, 1'b0, 4'd10},
        '{SMODE,2'd0, T1,  7'h10, 32'h1,        1'b0, 32'h0,        4'b0000, 1'b0, 1'b1, 4'd10},
        // transactional mode, R4 R6 R7 R8
        '{UWR,  2'd1, T3,  7'h05, 32'h11110005, 1'b0, 32'h0,        4'b0000, 1'b0, 1'b1, 4'd4},
        '{LWR,  2'd1, T3,  7'h05, 32'h22220006, 1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd4},
        '{URD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h11110005, 4'b0010, 1'b0, 1'b1, 4'd4},
        '{LRD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h22220006, 4'b0010, 1'b0, 1'b1, 4'd4},
        '{STO,  2'd1, T3,  7'h05, 32'h0,        1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd6},
        '{LRD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h11110005, 4'b0010, 1'b0, 1'b1, 4'd6},
        '{UWR,  2'd1, T3,  7'h05, 32'h33330007, 1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd6},
        '{RES,  2'd1, T3,  7'h05, 32'h0,        1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd6},
        '{URD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h11110005, 4'b0010, 1'b0, 1'b1, 4'd6},
        '{DUA,  2'd3, T4,  7'h07, 32'h44440008, 1'b0, 32'h0,        4'b0000, 1'b0, 1'b1, 4'd7},
        '{URD,  2'd3, T4,  7'h07, 32'h0,        1'b1, 32'h44440008, 4'b1000, 1'b0, 1'b1, 4'd7},
        '{LRD,  2'd3, T4,  7'h07, 32'h0,        1'b1, 32'h44440008, 4'b1000, 1'b0, 1'b1, 4'd7},
        '{UWR,  2'd1, T3,  7'h05, 32'h55550009, 1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd8},
        '{SALL, 2'd1, T3,  7'h05, 32'h0,        1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd8},
        '{LRD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h55550009, 4'b0010, 1'b0, 1'b1, 4'd8},
        '{URD,  2'd1, T3X, 7'h05, 32'h0,        1'b1, 32'h55550009, 4'b0000, 1'b0, 1'b1, 4'd4},
        '{INV,  2'd1, T3,  7'h05, 32'h0,        1'b0, 32'h0,        4'b0010, 1'b0, 1'b1, 4'd10},
        '{URD,  2'd1, T3,  7'h05, 32'h0,        1'b1, 32'h55550009, 4'b0000, 1'b0, 1'b1, 4'd10},
        '{SMODE,2'd0, T1,  7'h10, 32'h0,        1'b0, 32'h0,        4'b0000, 1'b1, 1'b1, 4'd10}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_op = '0;
    logic [1:0]   req_way = '0;
    logic [47:0]  req_addr = '0;
    logic [511:0] req_wdata = '0;
    logic         rsp_valid;
    logic [511:0] rsp_data;
    logic [3:0]   rsp_hit;
    logic         rsp_err;
    logic         tm_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dvcache_array dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_way(req_way), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .tm_mode(tm_mode)
    );

    function automatic logic [47:0] mk(input logic [34:0] t, input logic [6:0] l);
        return {t, l, 6'b0};
    endfunction

    task automatic check(input string rq, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act[31:0], exp[31:0]);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [1:0] w,
                         input logic [47:0] a, input logic [31:0] p);
        req_valid = 1'b1;
        req_op    = op;
        req_way   = w;
        req_addr  = a;
        req_wdata = {16{p}};
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "tm_mode", 512'(tm_mode), 512'(0));
        check("R1", "rsp_valid", 512'(rsp_valid), 512'(0));
        check("R2", "req_ready", 512'(req_ready), 512'(1));

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d", VECS[i].rq);
            drive(VECS[i].op, VECS[i].way, mk(VECS[i].tag, VECS[i].low), VECS[i].wpat);
            @(negedge clk);
            req_valid = 1'b0;
            check("R2", $sformatf("vec%0d rsp_valid", i), 512'(rsp_valid), 512'(1));
            check(rq, $sformatf("vec%0d hit", i), 512'(rsp_hit), 512'(VECS[i].hit));
            check(rq, $sformatf("vec%0d err", i), 512'(rsp_err), 512'(VECS[i].err));
            check(rq, $sformatf("vec%0d mode", i), 512'(tm_mode), 512'(VECS[i].mode));
            if (VECS[i].chk_d)
                check(rq, $sformatf("vec%0d data", i), rsp_data, {16{VECS[i].dpat}});
            else if (VECS[i].op != URD && VECS[i].op != LRD)
                check("R2", $sformatf("vec%0d zero data", i), rsp_data, '0);
        end

        // R2: idle cycle gives no response
        @(negedge clk);
        check("R2", "idle rsp_valid", 512'(rsp_valid), 512'(0));

        // R2 R5: read then write of the same line back to back (transactional mode)
        drive(URD, 2'd3, mk(T4, 7'h07), 32'h0);
        @(negedge clk);
        drive(UWR, 2'd3, mk(T4, 7'h07), 32'h66660010);
        check("R2", "b2b read old data", rsp_data, {16{32'h44440008}});
        check("R5", "b2b read hit", 512'(rsp_hit), 512'(4'b1000));
        @(negedge clk);
        drive(URD, 2'd3, mk(T4, 7'h07), 32'h0);
        check("R2", "b2b write rsp", 512'(rsp_valid), 512'(1));
        check("R2", "b2b write no err", 512'(rsp_err), 512'(0));
        @(negedge clk);
        req_valid = 1'b0;
        check("R4", "b2b new upper", rsp_data, {16{32'h66660010}});
        @(negedge clk);
        drive(LRD, 2'd3, mk(T4, 7'h07), 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4", "lower untouched by upper write", rsp_data, {16{32'h44440008}});

        finish_run();
    end
endmodule